// File: doc/BRIEF.md
# Selective Row Refresh Sweeper

This block keeps one address range of a DRAM alive after the controller's global refresh has been switched off. Opening a row through any read restores every cell in it, so a single word read per row is enough. At the start of each refresh period the sweeper walks the protected range one row at a time and issues one read per row. Memory outside that range is never addressed by the sweeper. This leaves a separate region free to decay undisturbed while the system keeps running.

The sweeper shares one read port with a host. The host always wins a cycle unless the sweep would otherwise miss its deadline. A sweep read becomes urgent when the rows still to be read are at least as many as the cycles left in the period. While a read is urgent the host is stalled. Read data that returns for sweep reads is swallowed and never reaches the host.

Two status outputs are provided. One reports how long the last completed sweep took. A sticky flag is set when a period began before the previous sweep had finished.

The design is built around a three-state walker:
- **OFF**: the engine is disabled.
- **WAIT**: idle between sweeps.
- **SWEEP**: issuing row reads.

Its named transitions are:
- **T_ENABLE**: OFF→SWEEP, or OFF→WAIT when the range is empty.
- **T_START**: WAIT→SWEEP at a period start.
- **T_DONE**: SWEEP→WAIT after the last row is read.
- **T_RESTART**: SWEEP→SWEEP at a period start that finds the sweep unfinished.
- **T_DISABLE**: any state→OFF.

Top module: `selrow_refresh`

## Requirements
- R1: After reset the block issues no sweep read, and `host_rvalid`, `overrun` and `sweep_cycles` are all 0.
- R2: A period starts on the first enabled cycle and then every `period_cycles` cycles. The period-start cycle issues no sweep read. Each sweep reads every row of the range exactly once, that is (`prot_limit`-`prot_base`+1)/2^ROW_SHIFT rows.
- R3: Sweep read addresses ascend as `prot_base` + k·2^ROW_SHIFT, with k counting from 0. None lies outside [`prot_base`, `prot_limit`].
- R4: A host request is granted in the same cycle (`host_gnt`=1, `mem_addr`=`host_addr`) unless a sweep read is urgent. Sweep reads otherwise use only cycles the host leaves idle. A sweep read is visible as `mem_req`=1 with `host_gnt`=0.
- R5: A sweep read is urgent when the rows left are at least `period_cycles` minus the position in the period. A sweep of at most `period_cycles`-1 rows therefore completes inside its period even under a saturating host. In that case the host is stalled for exactly one cycle per row.
- R6: `sweep_cycles` holds the number of cycles from the cycle after the period start to the cycle of the last row read, both counted. It updates when a sweep completes.
- R7: A period start that finds a sweep unfinished sets `overrun` and restarts the sweep at `prot_base`. `overrun` stays set until the block is disabled or reset.
- R8: Read data returns on `mem_rvalid` exactly RD_LAT cycles after the request. It is forwarded unchanged on `host_rvalid`/`host_rdata` only for host reads. Sweep read data is discarded.
- R9: While `enable` is 0 no sweep read is issued, the row pointer returns to `prot_base` and `overrun` clears. A re-enabled engine starts its next sweep at `prot_base`.
- R10: If `prot_limit` < `prot_base` the range is empty and no sweep read is ever issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Engine on (global refresh assumed off) |
| period_cycles | input | PER_W | Refresh period in clock cycles |
| prot_base | input | ADDR_W | First word address of protected range (row aligned) |
| prot_limit | input | ADDR_W | Last word address of protected range |
| host_req | input | 1 | Host read request |
| host_addr | input | ADDR_W | Host read address |
| host_gnt | output | 1 | Host request accepted this cycle |
| host_rvalid | output | 1 | Returned data belongs to a host read |
| host_rdata | output | DATA_W | Host read data |
| mem_req | output | 1 | Read request to memory |
| mem_addr | output | ADDR_W | Read address to memory |
| mem_rvalid | input | 1 | Memory read data valid (fixed latency RD_LAT) |
| mem_rdata | input | DATA_W | Memory read data |
| sweep_cycles | output | PER_W | Duration of the last completed sweep |
| overrun | output | 1 | Sticky: a period began before the sweep finished |

## Verification
Two things can fall in the same cycle. A host request can meet an urgent sweep read. A period start can meet a sweep that is still unfinished. The first case is provoked by holding `host_req` high for whole runs. The bench then checks that the host stalls for exactly one cycle per row, that every row is still read, and that `sweep_cycles` equals `period_cycles`-1. The second case is provoked by ranges with more rows than a period can hold. The bench then expects `overrun` set, a fresh walk from `prot_base` in each period, and exactly `period_cycles`-1 sweep reads per period. An alternating host pattern with enough slack checks that sweep reads stay in the idle cycles and never stall the host.

// File: rtl/selrow_pkg.sv
package selrow_pkg;

    typedef enum logic [1:0] {
        SW_OFF   = 2'd0,
        SW_WAIT  = 2'd1,
        SW_SWEEP = 2'd2
    } sweep_state_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/selrow_period_timer.sv
module selrow_period_timer #(
    parameter int PER_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PER_W-1:0] period_cycles,
    output logic             period_start,
    output logic [PER_W-1:0] cycles_left
);

    logic [PER_W-1:0] pos_q;
    logic             at_end;

    assign at_end       = pos_q >= (period_cycles - PER_W'(1));
    assign period_start = enable && (pos_q == '0);
    assign cycles_left  = period_cycles - pos_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (!enable) begin
            pos_q <= '0;
        end else if (at_end) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + PER_W'(1);
        end
    end

    // R2: inside a period the position only steps by one or wraps to zero
    p_period_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !period_start) |=> (pos_q == '0) || (pos_q == $past(pos_q) + PER_W'(1)));

endmodule

// File: rtl/selrow_row_walker.sv
module selrow_row_walker
    import selrow_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int PER_W     = 24,
    parameter int ROW_SHIFT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              period_start,
    input  logic [PER_W-1:0]  cycles_left,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  logic              host_req,
    output logic              sweep_issue,
    output logic [ADDR_W-1:0] sweep_addr,
    output logic              urgent,
    output logic [PER_W-1:0]  sweep_cycles,
    output logic              overrun
);

    localparam int CMP_W = max_int(ADDR_W, PER_W) + 1;
    localparam logic [ADDR_W-1:0] ROW_STEP = ADDR_W'(1) << ROW_SHIFT;

    sweep_state_e      state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic [PER_W-1:0]  dur_q;
    logic [PER_W-1:0]  last_q;
    logic              over_q;

    logic              range_ok;
    logic              live;
    logic [CMP_W-1:0]  rows_left;
    logic              is_last;

    assign range_ok  = limit >= base;
    assign live      = enable && !period_start;
    assign rows_left = CMP_W'((limit - ptr_q) >> ROW_SHIFT) + CMP_W'(1);
    assign is_last   = rows_left == CMP_W'(1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SW_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_OFF: begin
                // T_ENABLE
                if (enable && period_start) begin
                    state_d = range_ok ? SW_SWEEP : SW_WAIT;
                end else if (enable) begin
                    state_d = SW_WAIT;
                end
            end
            SW_WAIT: begin
                if (!enable) begin
                    state_d = SW_OFF;                      // T_DISABLE
                end else if (period_start && range_ok) begin
                    state_d = SW_SWEEP;                    // T_START
                end
            end
            SW_SWEEP: begin
                if (!enable) begin
                    state_d = SW_OFF;                      // T_DISABLE
                end else if (period_start) begin
                    state_d = range_ok ? SW_SWEEP : SW_WAIT; // T_RESTART
                end else if (sweep_issue && is_last) begin
                    state_d = SW_WAIT;                     // T_DONE
                end
            end
            default: state_d = SW_OFF;
        endcase
    end

    // outputs
    always_comb begin
        urgent      = 1'b0;
        sweep_issue = 1'b0;
        unique case (state_q)
            SW_SWEEP: begin
                urgent      = live && (rows_left >= CMP_W'(cycles_left));
                sweep_issue = live && (urgent || !host_req);
            end
            default: begin
                urgent      = 1'b0;
                sweep_issue = 1'b0;
            end
        endcase
    end

    // datapath: pointer, duration, status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            dur_q  <= '0;
            last_q <= '0;
            over_q <= 1'b0;
        end else if (!enable) begin
            ptr_q  <= base;
            dur_q  <= '0;
            over_q <= 1'b0;
        end else if (period_start) begin
            ptr_q <= base;
            dur_q <= '0;
            if (state_q == SW_SWEEP) begin
                over_q <= 1'b1;
            end
        end else if (state_q == SW_SWEEP) begin
            dur_q <= dur_q + PER_W'(1);
            if (sweep_issue) begin
                ptr_q <= ptr_q + ROW_STEP;
                if (is_last) begin
                    last_q <= dur_q + PER_W'(1);
                end
            end
        end
    end

    assign sweep_addr   = ptr_q;
    assign sweep_cycles = last_q;
    assign overrun      = over_q;

    // R9: a disabled engine parks its pointer on the range base
    p_ptr_home_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ptr_q == $past(base));

    // R7: overrun is sticky while enabled
    p_overrun_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (over_q && enable) |=> over_q);

    // R2: reading the last row ends the sweep
    p_last_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_issue && is_last) |=> state_q == SW_WAIT);

endmodule

// File: rtl/selrow_return_filter.sv
module selrow_return_filter #(
    parameter int DATA_W = 32,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_issue,
    input  logic              sweep_issue,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata
);

    logic sweep_tag_q [RD_LAT];
    logic host_tag_q  [RD_LAT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweep_tag_q[0] <= 1'b0;
            host_tag_q[0]  <= 1'b0;
        end else begin
            sweep_tag_q[0] <= sweep_issue;
            host_tag_q[0]  <= host_issue;
        end
    end

    for (genvar i = 1; i < RD_LAT; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sweep_tag_q[i] <= 1'b0;
                host_tag_q[i]  <= 1'b0;
            end else begin
                sweep_tag_q[i] <= sweep_tag_q[i-1];
                host_tag_q[i]  <= host_tag_q[i-1];
            end
        end
    end

    assign host_rvalid = mem_rvalid && !sweep_tag_q[RD_LAT-1];
    assign host_rdata  = host_rvalid ? mem_rdata : '0;

    // R8: data reaches the host only for a host read issued RD_LAT cycles ago
    p_host_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> host_tag_q[RD_LAT-1]);

endmodule

// File: rtl/selrow_refresh.sv
module selrow_refresh #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int PER_W     = 24,
    parameter int ROW_SHIFT = 6,
    parameter int RD_LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [PER_W-1:0]  period_cycles,
    input  logic [ADDR_W-1:0] prot_base,
    input  logic [ADDR_W-1:0] prot_limit,
    input  logic              host_req,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              host_gnt,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [PER_W-1:0]  sweep_cycles,
    output logic              overrun
);

    localparam logic [ADDR_W-1:0] ROW_MASK = (ADDR_W'(1) << ROW_SHIFT) - ADDR_W'(1);

    logic              period_start;
    logic [PER_W-1:0]  cycles_left;
    logic              sweep_issue;
    logic [ADDR_W-1:0] sweep_addr;
    logic              urgent;

    selrow_period_timer #(
        .PER_W(PER_W)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .period_cycles(period_cycles),
        .period_start (period_start),
        .cycles_left  (cycles_left)
    );

    selrow_row_walker #(
        .ADDR_W   (ADDR_W),
        .PER_W    (PER_W),
        .ROW_SHIFT(ROW_SHIFT)
    ) u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .period_start(period_start),
        .cycles_left (cycles_left),
        .base        (prot_base),
        .limit       (prot_limit),
        .host_req    (host_req),
        .sweep_issue (sweep_issue),
        .sweep_addr  (sweep_addr),
        .urgent      (urgent),
        .sweep_cycles(sweep_cycles),
        .overrun     (overrun)
    );

    assign host_gnt = host_req && !urgent;
    assign mem_req  = host_gnt || sweep_issue;
    assign mem_addr = sweep_issue ? sweep_addr : host_addr;

    selrow_return_filter #(
        .DATA_W(DATA_W),
        .RD_LAT(RD_LAT)
    ) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_issue (host_gnt),
        .sweep_issue(sweep_issue),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .host_rvalid(host_rvalid),
        .host_rdata (host_rdata)
    );

    // R3: sweep reads stay inside the range, on row boundaries
    p_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !host_gnt) |->
            (mem_addr >= prot_base) && (mem_addr <= prot_limit)
            && (((mem_addr - prot_base) & ROW_MASK) == '0));

    // R4: a host stall only happens when a sweep read takes the slot
    p_host_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_gnt) |-> mem_req);

    // R4: never two sources in one cycle
    p_one_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_gnt && sweep_issue));

endmodule

// File: tb/selrow_refresh_test.sv
module selrow_refresh_test;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int PW = 8;
    localparam int RS = 2;
    localparam int LAT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [PW-1:0] period_cycles = '0;
    logic [AW-1:0] prot_base = '0;
    logic [AW-1:0] prot_limit = '0;
    logic          host_req = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic          host_gnt;
    logic          host_rvalid;
    logic [DW-1:0] host_rdata;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid;
    logic [DW-1:0] mem_rdata;
    logic [PW-1:0] sweep_cycles;
    logic          overrun;

    always #2 clk = ~clk;

    selrow_refresh #(
        .ADDR_W(AW), .DATA_W(DW), .PER_W(PW), .ROW_SHIFT(RS), .RD_LAT(LAT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .period_cycles(period_cycles),
        .prot_base(prot_base), .prot_limit(prot_limit),
        .host_req(host_req), .host_addr(host_addr), .host_gnt(host_gnt),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .sweep_cycles(sweep_cycles), .overrun(overrun)
    );

    function automatic logic [DW-1:0] fdata(input logic [AW-1:0] a);
        return {16'hC0DE, a ^ 16'h5A5A};
    endfunction

    // memory model: fixed two-cycle read latency
    logic          v1 = 1'b0, v2 = 1'b0;
    logic [AW-1:0] a1 = '0, a2 = '0;
    always @(posedge clk) begin
        v1 <= mem_req;
        a1 <= mem_addr;
        v2 <= v1;
        a2 <= a1;
    end
    assign mem_rvalid = v2;
    assign mem_rdata  = fdata(a2);

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit run_on = 1'b0;
    bit watch_idle = 1'b0;
    int cyc = 0, k = 0, cur_p = 1, cur_base = 0, cur_limit = 0;
    int n_sweep = 0, bad_range = 0, bad_addr = 0, n_stall = 0, n_idle_req = 0;
    int n_hgnt = 0, n_hret = 0, bad_data = 0, hw = 0, hr = 0;
    logic [AW-1:0] hq [8];

    always @(negedge clk) begin
        if (run_on) begin
            if (cyc % cur_p == 0) k = 0;
            if (mem_req && !host_gnt) begin
                n_sweep++;
                if (int'(mem_addr) < cur_base || int'(mem_addr) > cur_limit) bad_range++;
                if (int'(mem_addr) != cur_base + (k << RS)) bad_addr++;
                k++;
            end
            if (host_req && !host_gnt) n_stall++;
        end
        if (watch_idle && mem_req) n_idle_req++;
        if (mem_req && host_gnt) begin
            hq[hw % 8] = host_addr;
            hw++;
            n_hgnt++;
        end
        if (host_rvalid) begin
            n_hret++;
            if (host_rdata != fdata(hq[hr % 8])) bad_data++;
            hr++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_cfg(input int rows, input int per, input int mode, input int nper, input bit empty);
        int base, limit, exp_n, lim_rows;
        bit over_exp;
        base  = 'h100 + rows * 'h40;
        limit = empty ? base - 1 : base + (rows << RS) - 1;
        enable = 1'b0;
        host_req = 1'b0;
        @(posedge clk); #1;
        prot_base = AW'(base);
        prot_limit = AW'(limit);
        period_cycles = PW'(per);
        cur_base = base; cur_limit = limit; cur_p = per;
        n_sweep = 0; bad_range = 0; bad_addr = 0; n_stall = 0;
        n_hgnt = 0; n_hret = 0; bad_data = 0;
        enable = 1'b1;
        cyc = 0;
        run_on = 1'b1;
        for (int i = 0; i < nper * per; i++) begin
            host_req  = (mode == 1) || (mode == 2 && (i % 2) == 0);
            host_addr = AW'('h800 + i);
            @(posedge clk); #1;
            cyc++;
        end
        host_req = 1'b0;
        lim_rows = (rows <= per - 1) ? rows : per - 1;
        exp_n    = empty ? 0 : nper * lim_rows;
        over_exp = !empty && (rows > per - 1);
        if (empty) chk(n_sweep == 0, "R10 empty range sweep reads", n_sweep, 0);
        else       chk(n_sweep == exp_n, "R2 sweep read count", n_sweep, exp_n);
        chk(bad_addr == 0, "R3 sweep address order", bad_addr, 0);
        chk(bad_range == 0, "R3 sweep address in range", bad_range, 0);
        if (mode == 1) chk(n_stall == exp_n, "R5 host stalls under saturation", n_stall, exp_n);
        if (mode == 2 && (per % 2) == 0 && 2 * rows <= per)
            chk(n_stall == 0, "R4 sweep uses idle host cycles", n_stall, 0);
        chk(overrun == over_exp, "R7 overrun flag", int'(overrun), int'(over_exp));
        if (!over_exp && !empty && mode == 0)
            chk(int'(sweep_cycles) == rows, "R6 sweep duration idle host", int'(sweep_cycles), rows);
        if (!over_exp && !empty && mode == 1)
            chk(int'(sweep_cycles) == per - 1, "R6 sweep duration busy host", int'(sweep_cycles), per - 1);
        enable = 1'b0;
        run_on = 1'b0;
        repeat (LAT + 2) @(posedge clk);
        #1;
        chk(n_hret == n_hgnt, "R8 host returns match host reads", n_hret, n_hgnt);
        chk(bad_data == 0, "R8 host data unchanged", bad_data, 0);
        chk(overrun == 1'b0, "R9 overrun cleared by disable", int'(overrun), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(mem_req == 1'b0, "R1 no request after reset", int'(mem_req), 0);
        chk(host_rvalid == 1'b0, "R1 host_rvalid after reset", int'(host_rvalid), 0);
        chk(overrun == 1'b0, "R1 overrun after reset", int'(overrun), 0);
        chk(sweep_cycles == '0, "R1 sweep_cycles after reset", int'(sweep_cycles), 0);

        // R9: disable mid-sweep, stay quiet, then restart from base
        @(posedge clk); #1;
        prot_base = AW'('h200);
        prot_limit = AW'('h200 + (6 << RS) - 1);
        period_cycles = PW'(9);
        enable = 1'b1;
        repeat (3) @(posedge clk);
        #1 enable = 1'b0;
        watch_idle = 1'b1;
        repeat (10) @(posedge clk);
        #1 watch_idle = 1'b0;
        chk(n_idle_req == 0, "R9 no reads while disabled", n_idle_req, 0);
        // the address check of the next run starts at k=0, so it also covers R9 pointer restart
        run_cfg(6, 9, 0, 2, 1'b0);

        foreach (hq[i]) hq[i] = '0;
        for (int m = 0; m < 3; m++) begin
            for (int pi = 0; pi < 2; pi++) begin
                for (int ri = 0; ri < 5; ri++) begin
                    int rv;
                    rv = (ri == 0) ? 1 : (ri == 1) ? 2 : (ri == 2) ? 3 : (ri == 3) ? 5 : 6;
                    run_cfg(rv, (pi == 0) ? 6 : 12, m, 3, 1'b0);
                end
            end
        end
        // R10 empty range
        run_cfg(3, 8, 0, 3, 1'b1);
        run_cfg(3, 8, 1, 2, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule